// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

A watchdog peripheral on a simple register bus. It has four 32-bit registers: control, count, limit and window. A free-running count advances on a tick from one of four sources, with an optional divide-by-256 stage. When the count reaches the limit, the peripheral sets a sticky expiry flag and may raise an interrupt. A fixed 128 cycles later it raises a reset request unless software services it in time.

Every write to the count register is read as a key. One key pair opens a short configuration session. Another key pair services the timer and restarts the count from zero. A mode bit selects the key width. In narrow mode a key is two 16-bit halves on consecutive count-register writes. In wide mode it is one 32-bit word. A wrong key, or a broken pair, requests a reset at once. Two status bits let software poll the handshake: "session open" and "settings applied".

The block is used by a boot or runtime agent in a fixed order. It opens a session, writes the limit and the window, and writes control. It then waits for "settings applied" and services the timer regularly after that. The reset request goes to the system reset controller, which lies outside this block.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, control reads 0x0000_0020 (only the update-allowed bit 5 set), limit reads 0xFFFF, window reads 0, count reads 0, and both irq_o and rst_req_o are low.
- R2: In narrow mode (control bit 13 = 0), two writes to the count register (address 1) open a session: 0xC520, then 0xD928 as the next count-register write. The open-session bit 11 then reads 1.
- R3: In wide mode (control bit 13 = 1), the single word 0xD928C520 opens a session and the single word 0xB480A602 services the timer.
- R4: Any other value written to the count register requests a reset on the next edge. In narrow mode this includes a second half that does not match the first half it follows. Writes to other registers do not break a pending pair. rst_req_o stays high until rst_ni.
- R5: A write to control (address 0), limit (address 2) or window (address 3) is ignored unless a session is open and bit 5 is 1. Once bit 5 is written to 0, it stays 0 until reset.
- R6: A session closes after 128 cycles or on the first accepted control write, whichever comes first.
- R7: The settings-applied bit 10 reads 1 after an accepted control write and is cleared when a session opens.
- R8: A service sequence (narrow: 0xA602 then 0xB480) sets the count to 0. An accepted control write also sets the count to 0.
- R9: With bit 7 set, the count advances once per tick of the source chosen by bits 9:8. Source 0 ticks every cycle; sources 1, 2 and 3 are lpo_tick_i, k32_tick_i and ext_tick_i. With bit 12 set, only every 256th source tick advances the count. The count stops at the limit.
- R10: On the edge after the count equals the limit, flag bit 14 is set. irq_o equals flag AND bit 6. Writing 1 to bit 14 in an accepted control write clears the flag.
- R11: rst_req_o rises 128 cycles after the flag is set, unless a service sequence completes first.
- R12: With a nonzero window, a service that completes while the count is below the window requests a reset. A window of 0 disables this check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Bus select |
| we_i | input | 1 | Write strobe, taken with sel_i at the rising edge |
| addr_i | input | 2 | Word address: 0 control, 1 count, 2 limit, 3 window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| lpo_tick_i | input | 1 | Low-power tick source (select 1) |
| k32_tick_i | input | 1 | 32 kHz tick source (select 2) |
| ext_tick_i | input | 1 | External tick source (select 3) |
| irq_o | output | 1 | Expiry interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
A key decoder stuck in a half-pair state shows up on the very next count-register write. That write either raises rst_req_o or fails to clear the count, so the fault is visible on the following edge. A session timer or prescaler that is off by one moves the edge on which bit 11 drops, or on which the count steps. This is caught by reading at exact cycle offsets. Errors in the expiry or grace logic move the cycle on which the flag, irq_o or rst_req_o rise. Randomised limits, checked at random offsets, expose them within one timeout plus 128 cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_TOV  = 2'd2;
  localparam logic [1:0] A_WIN  = 2'd3;

  localparam int B_UPD = 5;
  localparam int B_IE  = 6;
  localparam int B_EN  = 7;
  localparam int B_CS  = 8;
  localparam int B_RCS = 10;
  localparam int B_ULK = 11;
  localparam int B_PRE = 12;
  localparam int B_C32 = 13;
  localparam int B_FLG = 14;

  localparam logic [15:0] SVC_LO  = 16'hA602;
  localparam logic [15:0] SVC_HI  = 16'hB480;
  localparam logic [15:0] OPEN_LO = 16'hC520;
  localparam logic [15:0] OPEN_HI = 16'hD928;

  typedef struct packed {
    logic       upd;
    logic       ie;
    logic       en;
    logic [1:0] cs;
    logic       pre;
    logic       c32;
  } cfg_t;

  typedef enum logic [1:0] {K_IDLE, K_SVC, K_OPEN} key_st_e;
endpackage

// File: rtl/wdt_key_check.sv
module wdt_key_check
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] word_i,
  input  logic        c32_i,
  output logic        svc_o,
  output logic        open_o,
  output logic        bad_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    svc_o  = 1'b0;
    open_o = 1'b0;
    bad_o  = 1'b0;
    if (wr_i) begin
      st_d = K_IDLE;
      if (c32_i) begin
        if (word_i == {SVC_HI, SVC_LO})        svc_o  = 1'b1;
        else if (word_i == {OPEN_HI, OPEN_LO}) open_o = 1'b1;
        else                                   bad_o  = 1'b1;
      end else begin
        unique case (st_q)
          K_IDLE: begin
            if (word_i[15:0] == SVC_LO)       st_d  = K_SVC;
            else if (word_i[15:0] == OPEN_LO) st_d  = K_OPEN;
            else                              bad_o = 1'b1;
          end
          K_SVC: begin
            if (word_i[15:0] == SVC_HI) svc_o = 1'b1;
            else                        bad_o = 1'b1;
          end
          K_OPEN: begin
            if (word_i[15:0] == OPEN_HI) open_o = 1'b1;
            else                         bad_o  = 1'b1;
          end
          default: bad_o = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= K_IDLE;
    else         st_q <= st_d;
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int PRE_DIV = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  input  logic       pre_en_i,
  input  logic       lpo_tick_i,
  input  logic       k32_tick_i,
  input  logic       ext_tick_i,
  output logic       tick_o
);
  logic src;

  always_comb
    unique case (sel_i)
      2'd0:    src = 1'b1;
      2'd1:    src = lpo_tick_i;
      2'd2:    src = k32_tick_i;
      default: src = ext_tick_i;
    endcase

  if (PRE_DIV > 1) begin : g_pre
    localparam int PW = $clog2(PRE_DIV);
    logic [PW-1:0] pre_q;
    logic          wrap;
    assign wrap = (pre_q == PW'(PRE_DIV - 1));
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)             pre_q <= '0;
      else if (clr_i || !pre_en_i) pre_q <= '0;
      else if (src)            pre_q <= wrap ? '0 : pre_q + 1'b1;
    assign tick_o = src && (!pre_en_i || wrap);
  end else begin : g_nopre
    logic unused_pre;
    assign unused_pre = pre_en_i ^ clr_i;
    assign tick_o = src;
  end
endmodule

// File: rtl/wdt_cnt.sv
module wdt_cnt #(
  parameter int CNT_W     = 16,
  parameter int GRACE_CYC = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             grace_done_o
);
  localparam int GW = $clog2(GRACE_CYC) > 0 ? $clog2(GRACE_CYC) : 1;

  logic          exp_q;
  logic [GW-1:0] grc_q;

  assign hit_o        = en_i && !exp_q && (cnt_o >= limit_i);
  assign grace_done_o = exp_q && (grc_q == GW'(GRACE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_o <= '0;
      exp_q <= 1'b0;
      grc_q <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
      exp_q <= 1'b0;
      grc_q <= '0;
    end else begin
      if (hit_o) begin
        exp_q <= 1'b1;
        grc_q <= '0;
      end else if (exp_q && !grace_done_o) begin
        grc_q <= grc_q + 1'b1;
      end
      if (en_i && tick_i && cnt_o < limit_i) cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PRE_DIV    = 256,
  parameter int UNLOCK_CYC = 128,
  parameter int GRACE_CYC  = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        lpo_tick_i,
  input  logic        k32_tick_i,
  input  logic        ext_tick_i,
  output logic        irq_o,
  output logic        rst_req_o
);
  localparam int UW = $clog2(UNLOCK_CYC) > 0 ? $clog2(UNLOCK_CYC) : 1;

  cfg_t             cfg_q;
  logic             ulk_q, rcs_q, flg_q;
  logic [UW-1:0]    ut_q;
  logic [CNT_W-1:0] toval_q, win_q, cnt;
  logic             wr, cnt_wr, cfg_ok, ctrl_ok;
  logic             svc, opn, bad, win_viol, clr, tick, hit, grace_done;
  logic [31:0]      ctrl_rd;

  assign wr      = sel_i && we_i;
  assign cnt_wr  = wr && addr_i == A_CNT;
  assign cfg_ok  = wr && ulk_q && cfg_q.upd;
  assign ctrl_ok = cfg_ok && addr_i == A_CTRL;

  wdt_key_check u_key (
    .clk_i, .rst_ni, .wr_i(cnt_wr), .word_i(wdata_i), .c32_i(cfg_q.c32),
    .svc_o(svc), .open_o(opn), .bad_o(bad)
  );

  assign win_viol = svc && (win_q != '0) && (cnt < win_q);
  assign clr      = svc || ctrl_ok;

  wdt_tick_gen #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk_i, .rst_ni, .clr_i(clr), .sel_i(cfg_q.cs), .pre_en_i(cfg_q.pre),
    .lpo_tick_i, .k32_tick_i, .ext_tick_i, .tick_o(tick)
  );

  wdt_cnt #(.CNT_W(CNT_W), .GRACE_CYC(GRACE_CYC)) u_cnt (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(cfg_q.en), .tick_i(tick),
    .limit_i(toval_q), .cnt_o(cnt), .hit_o(hit), .grace_done_o(grace_done)
  );

  // session window and handshake bits
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ulk_q <= 1'b0;
      ut_q  <= '0;
      rcs_q <= 1'b0;
    end else if (opn) begin
      ulk_q <= 1'b1;
      ut_q  <= '0;
      rcs_q <= 1'b0;
    end else if (ctrl_ok) begin
      ulk_q <= 1'b0;
      rcs_q <= 1'b1;
    end else if (ulk_q) begin
      if (ut_q == UW'(UNLOCK_CYC - 1)) ulk_q <= 1'b0;
      else                             ut_q  <= ut_q + 1'b1;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cfg_q   <= '{upd: 1'b1, default: '0};
      toval_q <= '1;
      win_q   <= '0;
    end else if (cfg_ok) begin
      unique case (addr_i)
        A_CTRL: cfg_q <= '{upd: wdata_i[B_UPD], ie: wdata_i[B_IE], en: wdata_i[B_EN],
                           cs: wdata_i[B_CS +: 2], pre: wdata_i[B_PRE], c32: wdata_i[B_C32]};
        A_TOV:  toval_q <= wdata_i[CNT_W-1:0];
        A_WIN:  win_q   <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      flg_q     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      if (hit)                              flg_q <= 1'b1;
      else if (ctrl_ok && wdata_i[B_FLG])   flg_q <= 1'b0;
      if (bad || win_viol || grace_done)    rst_req_o <= 1'b1;
    end

  assign irq_o = flg_q && cfg_q.ie;

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[B_UPD]      = cfg_q.upd;
    ctrl_rd[B_IE]       = cfg_q.ie;
    ctrl_rd[B_EN]       = cfg_q.en;
    ctrl_rd[B_CS +: 2]  = cfg_q.cs;
    ctrl_rd[B_RCS]      = rcs_q;
    ctrl_rd[B_ULK]      = ulk_q;
    ctrl_rd[B_PRE]      = cfg_q.pre;
    ctrl_rd[B_C32]      = cfg_q.c32;
    ctrl_rd[B_FLG]      = flg_q;
  end

  always_comb
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_rd;
      A_CNT:   rdata_o = 32'(cnt);
      A_TOV:   rdata_o = 32'(toval_q);
      default: rdata_o = 32'(win_q);
    endcase
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic             rst_req_o,
  input cfg_t             cfg_q,
  input logic             ulk_q,
  input logic             rcs_q,
  input logic             flg_q,
  input logic             svc,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] toval_q
);
  logic wr;
  assign wr = sel_i && we_i;

  assert_bad_wide_key_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_CNT && cfg_q.c32 && wdata_i != {SVC_HI, SVC_LO}
     && wdata_i != {OPEN_HI, OPEN_LO}) |=> rst_req_o);

  assert_rst_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);

  assert_locked_ctrl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_CTRL && !ulk_q) |=> $stable(cfg_q));

  assert_session_close_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_CTRL && ulk_q && cfg_q.upd) |=> !ulk_q);

  assert_applied_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_CTRL && ulk_q && cfg_q.upd) |=> rcs_q);

  assert_service_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc |=> cnt == '0);

  assert_flag_at_limit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flg_q) |-> $past(cnt >= toval_q));
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rst_req_o(rst_req_o), .cfg_q(cfg_q), .ulk_q(ulk_q),
  .rcs_q(rcs_q), .flg_q(flg_q), .svc(svc), .cnt(cnt), .toval_q(toval_q)
);

// File: tb/wdt_keyed_test.sv
`timescale 1ns/1ps
module wdt_keyed_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0, we_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        lpo_tick_i = 1'b0, k32_tick_i = 1'b0, ext_tick_i = 1'b0;
  logic        irq_o, rst_req_o;
  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  wdt_keyed uut (.*);

  function automatic logic [31:0] ctrlw(bit upd, bit ie, bit en, bit [1:0] cs,
                                        bit pre, bit c32, bit flg);
    return (32'(upd) << 5) | (32'(ie) << 6) | (32'(en) << 7) | (32'(cs) << 8) |
           (32'(pre) << 12) | (32'(c32) << 13) | (32'(flg) << 14);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    sel_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    waitn(2); rst_ni = 1'b1;
  endtask

  task automatic open16();  wr(1, 32'hC520); wr(1, 32'hD928); endtask
  task automatic svc16();   wr(1, 32'hA602); wr(1, 32'hB480); endtask

  task automatic pulse_lpo();
    lpo_tick_i = 1'b1; @(negedge clk_i); lpo_tick_i = 1'b0;
    k32_tick_i = 1'b1; @(negedge clk_i); k32_tick_i = 1'b0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 32'h20);
    rd(2, v); chk("R1 limit", v, 32'hFFFF);
    rd(3, v); chk("R1 window", v, 0);
    rd(1, v); chk("R1 count", v, 0);
    chk("R1 rst_req", 32'(rst_req_o), 0);
    chk("R1 irq", 32'(irq_o), 0);

    // R5 locked writes ignored
    wr(0, ctrlw(1, 1, 1, 0, 0, 0, 0)); wr(2, 32'd5);
    rd(0, v); chk("R5 locked ctrl", v, 32'h20);
    rd(2, v); chk("R5 locked limit", v, 32'hFFFF);

    // R2 narrow open, R7 applied bit, R6 close on ctrl write
    open16();
    rd(0, v); chk("R2 open bit", 32'(v[11]), 1);
    chk("R7 applied low after open", 32'(v[10]), 0);
    wr(2, 32'd100);
    wr(0, ctrlw(1, 0, 1, 0, 0, 0, 0));
    rd(0, v); chk("R6 closed by ctrl", 32'(v[11]), 0);
    chk("R7 applied", 32'(v[10]), 1);
    rd(2, v); chk("R5 limit written", v, 100);

    // R8 service restarts count
    waitn(30); rd(1, v); chk("R9 count bus clock", v, 30);
    svc16(); rd(1, v); chk("R8 count zero", v, 0);
    waitn(5); rd(1, v); chk("R8 count resumes", v, 5);

    // R6 session timeout
    do_reset(); open16();
    waitn(127); rd(0, v); chk("R6 open at 127", 32'(v[11]), 1);
    waitn(1); rd(0, v); chk("R6 closed at 128", 32'(v[11]), 0);
    wr(0, ctrlw(1, 0, 1, 0, 0, 0, 0)); rd(0, v); chk("R6 write after close", v, 32'h20);

    // R5 update-allowed cleared locks config
    do_reset(); open16(); wr(0, ctrlw(0, 0, 0, 0, 0, 0, 0));
    open16(); wr(0, ctrlw(1, 0, 1, 0, 0, 0, 0));
    rd(0, v); chk("R5 upd lock en", 32'(v[7]), 0);
    chk("R5 upd lock upd", 32'(v[5]), 0);

    // R4 bad keys
    do_reset(); wr(1, 32'hA602); wr(1, 32'hC520);
    chk("R4 broken pair", 32'(rst_req_o), 1);
    waitn(3); chk("R4 sticky", 32'(rst_req_o), 1);
    do_reset(); wr(1, 32'h1234); chk("R4 bad first half", 32'(rst_req_o), 1);
    do_reset(); wr(1, 32'hA602); wr(2, 32'h7); wr(1, 32'hB480);
    chk("R4 other reg between halves", 32'(rst_req_o), 0);

    // R3 wide mode
    do_reset(); open16(); wr(0, ctrlw(1, 0, 0, 0, 0, 1, 0));
    wr(1, 32'hD928C520); rd(0, v); chk("R3 wide open", 32'(v[11]), 1);
    wr(0, ctrlw(1, 0, 1, 0, 0, 1, 0));
    waitn(20); wr(1, 32'hB480A602); rd(1, v); chk("R3 wide service", v, 0);
    chk("R3 wide service no rst", 32'(rst_req_o), 0);
    wr(1, 32'h0000A602); chk("R4 half key in wide mode", 32'(rst_req_o), 1);

    // R9 prescaler and source select
    do_reset(); open16(); wr(0, ctrlw(1, 0, 1, 0, 1, 0, 0));
    waitn(256 * 3 + 10); rd(1, v); chk("R9 prescaled count", v, 3);
    do_reset(); open16(); wr(0, ctrlw(1, 0, 1, 1, 0, 0, 0));
    for (int i = 0; i < 7; i++) pulse_lpo();
    rd(1, v); chk("R9 lpo source", v, 7);

    // R10 flag, irq, W1C
    do_reset(); open16(); wr(2, 32'd10); wr(0, ctrlw(1, 1, 1, 0, 0, 0, 0));
    waitn(20); rd(0, v); chk("R10 flag", 32'(v[14]), 1);
    chk("R10 irq", 32'(irq_o), 1);
    open16(); wr(0, ctrlw(1, 1, 1, 0, 0, 0, 1));
    rd(0, v); chk("R10 w1c flag", 32'(v[14]), 0);
    chk("R10 w1c irq", 32'(irq_o), 0);

    // R11 service in grace prevents reset
    do_reset(); open16(); wr(2, 32'd10); wr(0, ctrlw(1, 0, 1, 0, 0, 0, 0));
    waitn(100); chk("R11 no rst in grace", 32'(rst_req_o), 0);
    svc16(); waitn(100); chk("R11 service saved", 32'(rst_req_o), 0);
    waitn(45); chk("R11 rst after second expiry", 32'(rst_req_o), 1);

    // R12 window
    do_reset(); open16(); wr(2, 32'd1000); wr(3, 32'd50);
    wr(0, ctrlw(1, 0, 1, 0, 0, 1, 0));
    wr(1, 32'hB480A602); chk("R12 early service", 32'(rst_req_o), 1);
    do_reset(); open16(); wr(2, 32'd1000); wr(3, 32'd50);
    wr(0, ctrlw(1, 0, 1, 0, 0, 1, 0));
    waitn(60); wr(1, 32'hB480A602);
    chk("R12 late service ok", 32'(rst_req_o), 0);
    rd(1, v); chk("R12 count cleared", v, 0);

    // random limits and sample points: R9 R10 R11
    for (int it = 0; it < 8; it++) begin
      int t, k;
      bit ie, c32;
      t = $urandom_range(5, 60);
      k = $urandom_range(0, t + 150);
      ie = 1'($urandom_range(0, 1));
      c32 = 1'($urandom_range(0, 1));
      do_reset(); open16(); wr(2, 32'(t));
      wr(0, ctrlw(1, ie, 1, 0, 0, c32, 0));
      waitn(k);
      rd(1, v); chk("R9 rand count", v, 32'(k < t ? k : t));
      rd(0, v); chk("R10 rand flag", 32'(v[14]), 32'(k >= t + 1));
      chk("R10 rand irq", 32'(irq_o), 32'(ie && k >= t + 1));
      chk("R11 rand rst", 32'(rst_req_o), 32'(k >= t + 129));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule